// File: doc/BRIEF.md
# Masked Vector AND-NOT Unit

This unit is the execution datapath for a lane-wise bitwise AND-NOT on a 512-bit vector. The vector is split into eight 64-bit lanes. In every lane that is written, the result is the bitwise complement of the first operand ANDed with the second operand. A decoder that sits upstream supplies the operands and a set of control fields with each operation. These fields give the encoding class, the vector length, the write mask, the zeroing or merging choice, the broadcast choice and whether the second source came from memory. The unit returns the complete new destination value one clock later.

The three encoding classes differ in two ways: which operand is inverted, and what happens to the lanes above the active length.

- **Legacy two-operand class.** The old destination is the inverted operand. Only the two lowest lanes are written, and every lane above them keeps its old content.
- **Unmasked three-operand class.** Every lane from the active lane count upward is cleared.
- **Masked three-operand class.** The same clearing applies. In addition, each lane is enabled by its own mask bit, and a disabled lane is either zeroed or merged. When the second source came from memory, lane 0 of the second source can be broadcast to every lane.

Illegal combinations of class and length are reported on an error flag. For those, the old destination is returned unchanged.

Top module: `vandn_unit`

## Requirements
- R1: In every written lane the result equals (NOT first operand) AND second operand. Only the first operand is inverted.
- R2: `in_vlen` selects the active lane count: code 0 gives 2 lanes (128 bits), code 1 gives 4 lanes (256 bits) and code 2 gives 8 lanes (512 bits).
- R3: Legacy class (`in_cls`=0) uses `in_dst` as the inverted operand and ignores `in_src1`. It writes lanes 0 and 1, and lanes 2 to 7 keep their `in_dst` values.
- R4: In the unmasked class (`in_cls`=1) and the masked class (`in_cls`=2), every lane whose index is at or above the active lane count is output as zero.
- R5: In the masked class, an active lane whose bit in `in_mask` is 1 receives the AND-NOT result. Bit i of `in_mask` belongs to lane i, which is bits [64*i+63:64*i].
- R6: In the masked class, an active lane whose mask bit is 0 outputs zero when `in_zero`=1. Otherwise it outputs its `in_dst` value.
- R7: In the masked class with `in_bcast`=1 and `in_memop`=1, every active lane uses `in_src2[63:0]` as its second operand, while the first operand stays per-lane.
- R8: `in_bcast` has no effect when `in_memop`=0, and it has no effect in the legacy and unmasked classes.
- R9: In the unmasked class, `in_mask` and `in_zero` have no effect, and every active lane is written.
- R10: The result appears on `out_data` with `out_valid` high in the cycle after `in_valid` is sampled high. `out_valid` is high for exactly one cycle per operation. After reset, `out_valid`, `out_err` and `out_data` are 0.
- R11: An error is any of: `in_vlen`=3, `in_cls`=3, or legacy class with `in_vlen` other than 0. On an error, `out_err`=1 and `out_data` equals `in_dst`. Otherwise `out_err`=0 alongside `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_cls | input | 2 | Encoding class: 0 legacy, 1 unmasked, 2 masked, 3 reserved |
| in_vlen | input | 2 | Vector length: 0 is 128, 1 is 256, 2 is 512, 3 reserved |
| in_zero | input | 1 | Masked class: 1 zeroes disabled lanes, 0 merges them |
| in_bcast | input | 1 | Broadcast lane 0 of the second source |
| in_memop | input | 1 | Second source came from memory |
| in_mask | input | 8 | Per-lane write mask |
| in_src1 | input | 512 | First source (inverted operand) |
| in_src2 | input | 512 | Second source |
| in_dst | input | 512 | Old destination value |
| out_valid | output | 1 | Result valid, one-cycle pulse |
| out_err | output | 1 | Illegal class/length combination |
| out_data | output | 512 | New destination value |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid pulse;
- the clearing of lanes above 128 bits in the three-operand classes;
- the preservation of the upper lanes in the legacy class;
- the pass-through of the destination on an error;
- the all-zero and all-merge outcomes of an empty mask;
- broadcast into the top lane.

The bench scenarios show the rest:
- the mixed per-lane outcomes of arbitrary mask patterns;
- that `in_src1` is really ignored in the legacy class;
- that broadcast is ignored for register operands and in the unmasked class;
- that mask and zeroing have no effect in the unmasked class;
- correct results across back-to-back operations with random data.

// File: rtl/vandn_pkg.sv
package vandn_pkg;
  localparam int LANE_W = 64;
  localparam int LANES  = 8;
  localparam int LEGACY_LANES = 2;

  typedef enum logic [1:0] {
    CLS_LEGACY = 2'd0,
    CLS_PLAIN  = 2'd1,
    CLS_MASKED = 2'd2,
    CLS_RSVD   = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    ACT_CALC  = 2'd0,
    ACT_KEEP  = 2'd1,
    ACT_CLEAR = 2'd2
  } lane_act_e;
endpackage

// File: rtl/vandn_ctrl.sv
module vandn_ctrl
  import vandn_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic [1:0]  cls,
  input  logic [1:0]  vlen,
  input  logic        zero,
  input  logic        bcast,
  input  logic        memop,
  input  logic [NLANES-1:0] mask,
  output lane_act_e [NLANES-1:0] act,
  output logic        bcast_sel,
  output logic        a_from_dst,
  output logic        err
);
  logic [4:0] n_act;

  always_comb begin
    case (vlen)
      2'd0:    n_act = 5'd2;
      2'd1:    n_act = 5'd4;
      default: n_act = 5'd8;
    endcase
  end

  always_comb begin
    err = (cls == CLS_RSVD) || (vlen == 2'd3) ||
          ((cls == CLS_LEGACY) && (vlen != 2'd0));
    bcast_sel  = (cls == CLS_MASKED) && bcast && memop;
    a_from_dst = (cls == CLS_LEGACY);
    for (int i = 0; i < NLANES; i++) begin
      if (err) begin
        act[i] = ACT_KEEP;
      end else begin
        case (cls)
          CLS_LEGACY: act[i] = (i < LEGACY_LANES) ? ACT_CALC : ACT_KEEP;
          CLS_PLAIN:  act[i] = (i < int'(n_act)) ? ACT_CALC : ACT_CLEAR;
          CLS_MASKED: begin
            if (i >= int'(n_act))  act[i] = ACT_CLEAR;
            else if (mask[i])      act[i] = ACT_CALC;
            else if (zero)         act[i] = ACT_CLEAR;
            else                   act[i] = ACT_KEEP;
          end
          default:    act[i] = ACT_KEEP;
        endcase
      end
    end
  end
endmodule

// File: rtl/vandn_lane.sv
module vandn_lane
  import vandn_pkg::*;
#(
  parameter int W = LANE_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] old,
  input  lane_act_e    act,
  output logic [W-1:0] res
);
  always_comb begin
    case (act)
      ACT_CALC:  res = ~op_a & op_b;
      ACT_KEEP:  res = old;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/vandn_unit.sv
module vandn_unit
  import vandn_pkg::*;
#(
  parameter int W      = LANE_W,
  parameter int NLANES = LANES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [1:0]            in_cls,
  input  logic [1:0]            in_vlen,
  input  logic                  in_zero,
  input  logic                  in_bcast,
  input  logic                  in_memop,
  input  logic [NLANES-1:0]     in_mask,
  input  logic [W*NLANES-1:0]   in_src1,
  input  logic [W*NLANES-1:0]   in_src2,
  input  logic [W*NLANES-1:0]   in_dst,
  output logic                  out_valid,
  output logic                  out_err,
  output logic [W*NLANES-1:0]   out_data
);
  localparam int VW = W * NLANES;

  lane_act_e [NLANES-1:0] act;
  logic bcast_sel, a_from_dst, err;
  logic [VW-1:0] nxt;

  vandn_ctrl #(.NLANES(NLANES)) ctrl_i (
    .cls(in_cls), .vlen(in_vlen), .zero(in_zero), .bcast(in_bcast),
    .memop(in_memop), .mask(in_mask), .act(act), .bcast_sel(bcast_sel),
    .a_from_dst(a_from_dst), .err(err)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [W-1:0] a, b;
    assign a = a_from_dst ? in_dst[g*W +: W] : in_src1[g*W +: W];
    assign b = bcast_sel ? in_src2[W-1:0] : in_src2[g*W +: W];
    vandn_lane #(.W(W)) lane_i (
      .op_a(a), .op_b(b), .old(in_dst[g*W +: W]), .act(act[g]),
      .res(nxt[g*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & err;
      if (in_valid) out_data <= nxt;
    end
  end

  // R10: one result pulse per accepted operation
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R11: illegal combination passes destination through
  assert_err_passthru_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_vlen == 2'd3)) |=> (out_err && out_data == $past(in_dst)));

  // R4: three-operand classes clear lanes above 128 bits
  assert_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_vlen == 2'd0 && (in_cls == 2'd1 || in_cls == 2'd2))
      |=> out_data[VW-1:2*W] == '0);

  // R3: legacy keeps upper lanes and inverts old destination
  assert_legacy_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == 2'd0 && in_vlen == 2'd0)
      |=> (out_data[VW-1:2*W] == $past(in_dst[VW-1:2*W]) &&
           out_data[W-1:0] == (~$past(in_dst[W-1:0]) & $past(in_src2[W-1:0]))));

  // R6: empty mask with zeroing clears everything
  assert_mask_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == 2'd2 && in_vlen != 2'd3 && in_mask == '0 && in_zero)
      |=> out_data == '0);

  // R6: empty mask with merging keeps full-width destination
  assert_mask_merge_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == 2'd2 && in_vlen == 2'd2 && in_mask == '0 && !in_zero)
      |=> out_data == $past(in_dst));

  // R7: broadcast reaches the top lane
  assert_bcast_top_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == 2'd2 && in_vlen == 2'd2 && in_bcast && in_memop &&
     in_mask[NLANES-1])
      |=> out_data[VW-1 -: W] ==
          (~$past(in_src1[VW-1 -: W]) & $past(in_src2[W-1:0])));
endmodule

// File: tb/vandn_unit_tb.sv
module vandn_unit_tb_top;
  localparam int W = 64;
  localparam int N = 8;
  localparam int VW = W * N;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_zero = 0, in_bcast = 0, in_memop = 0;
  logic [1:0] in_cls = 0, in_vlen = 0;
  logic [N-1:0] in_mask = 0;
  logic [VW-1:0] in_src1 = 0, in_src2 = 0, in_dst = 0;
  logic out_valid, out_err;
  logic [VW-1:0] out_data;

  always #5 clk = ~clk;

  vandn_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_vlen(in_vlen), .in_zero(in_zero), .in_bcast(in_bcast),
    .in_memop(in_memop), .in_mask(in_mask), .in_src1(in_src1),
    .in_src2(in_src2), .in_dst(in_dst), .out_valid(out_valid),
    .out_err(out_err), .out_data(out_data)
  );

  typedef struct {
    logic [VW-1:0] data;
    logic          err;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic exp_t model(logic [1:0] c, logic [1:0] v, logic z,
      logic bc, logic mo, logic [N-1:0] m, logic [VW-1:0] s1,
      logic [VW-1:0] s2, logic [VW-1:0] d, string tag);
    exp_t e;
    int n;
    logic [W-1:0] a, b, r;
    e.tag = tag;
    e.err = (c == 2'd3) || (v == 2'd3) || (c == 2'd0 && v != 2'd0);
    e.data = d;
    if (e.err) return e;
    n = (v == 2'd0) ? 2 : (v == 2'd1) ? 4 : 8;
    for (int l = 0; l < N; l++) begin
      a = (c == 2'd0) ? d[l*W +: W] : s1[l*W +: W];
      b = (c == 2'd2 && bc && mo) ? s2[W-1:0] : s2[l*W +: W];
      r = ~a & b;
      if (c == 2'd0)      e.data[l*W +: W] = (l < 2) ? r : d[l*W +: W];
      else if (l >= n)    e.data[l*W +: W] = '0;
      else if (c == 2'd1) e.data[l*W +: W] = r;
      else if (m[l])      e.data[l*W +: W] = r;
      else                e.data[l*W +: W] = z ? '0 : d[l*W +: W];
    end
    return e;
  endfunction

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] x;
    for (int i = 0; i < VW / 32; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic issue(logic [1:0] c, logic [1:0] v, logic z, logic bc,
      logic mo, logic [N-1:0] m, logic [VW-1:0] s1, logic [VW-1:0] s2,
      logic [VW-1:0] d, string tag);
    @(negedge clk);
    in_valid = 1; in_cls = c; in_vlen = v; in_zero = z; in_bcast = bc;
    in_memop = mo; in_mask = m; in_src1 = s1; in_src2 = s2; in_dst = d;
    sb.push_back(model(c, v, z, bc, mo, m, s1, s2, d, tag));
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        if (out_data !== e.data || out_err !== e.err) begin
          fails++;
          $display("FAIL %s: actual data=%h err=%b expected data=%h err=%b",
                   e.tag, out_data, out_err, e.data, e.err);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] ones, s1, s2, d;
    ones = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_err !== 0 || out_data !== '0) begin
      fails++;
      $display("FAIL R10 reset: actual v=%b e=%b d=%h expected 0/0/0",
               out_valid, out_err, out_data);
    end

    s1 = rnd(); s2 = rnd(); d = rnd();
    // R1 basic AND-NOT, full width unmasked
    issue(2'd1, 2'd2, 0, 0, 0, 8'h00, s1, s2, d, "R1");
    issue(2'd1, 2'd2, 0, 0, 0, 8'h00, ones, ones, d, "R1");
    issue(2'd1, 2'd2, 0, 0, 0, 8'h00, '0, ones, d, "R1");
    idle(1);
    // R2 / R4 lengths
    issue(2'd1, 2'd0, 0, 0, 0, 8'h00, s1, ones, d, "R2");
    issue(2'd1, 2'd1, 0, 0, 0, 8'h00, s1, ones, d, "R2");
    issue(2'd2, 2'd1, 0, 0, 0, 8'hFF, s1, s2, d, "R4");
    issue(2'd2, 2'd0, 1, 0, 0, 8'hFF, s1, s2, ones, "R4");
    idle(2);
    // R3 legacy: src1 ignored
    issue(2'd0, 2'd0, 0, 0, 0, 8'h00, s1, s2, d, "R3");
    issue(2'd0, 2'd0, 1, 1, 1, 8'h5A, ones, s2, d, "R3");
    issue(2'd0, 2'd0, 0, 0, 0, 8'h00, '0, s2, d, "R3");
    // R5 / R6 mask patterns
    issue(2'd2, 2'd2, 0, 0, 0, 8'hA5, s1, s2, d, "R5");
    issue(2'd2, 2'd2, 1, 0, 0, 8'h3C, s1, s2, d, "R6");
    issue(2'd2, 2'd2, 0, 0, 0, 8'h00, s1, s2, d, "R6");
    issue(2'd2, 2'd2, 1, 0, 0, 8'h00, s1, s2, d, "R6");
    issue(2'd2, 2'd1, 0, 0, 0, 8'hF0, s1, s2, d, "R6");
    idle(1);
    // R7 broadcast memory form
    issue(2'd2, 2'd2, 0, 1, 1, 8'hFF, s1, s2, d, "R7");
    issue(2'd2, 2'd1, 1, 1, 1, 8'h0B, s1, s2, d, "R7");
    // R8 broadcast ignored
    issue(2'd2, 2'd2, 0, 1, 0, 8'hFF, s1, s2, d, "R8");
    issue(2'd1, 2'd2, 0, 1, 1, 8'hFF, s1, s2, d, "R8");
    // R9 mask/zero ignored in unmasked class
    issue(2'd1, 2'd2, 1, 0, 0, 8'h00, s1, s2, d, "R9");
    issue(2'd1, 2'd1, 0, 0, 0, 8'h12, s1, s2, d, "R9");
    idle(1);
    // R11 errors
    issue(2'd0, 2'd1, 0, 0, 0, 8'h00, s1, s2, d, "R11");
    issue(2'd1, 2'd3, 0, 0, 0, 8'hFF, s1, s2, d, "R11");
    issue(2'd3, 2'd0, 0, 0, 0, 8'hFF, s1, s2, d, "R11");
    issue(2'd2, 2'd2, 1, 0, 0, 8'h81, s1, s2, d, "R11");
    idle(3);
    // R10 idle gives no pulse
    checks++;
    if (out_valid !== 0) begin
      fails++;
      $display("FAIL R10 idle: actual out_valid=%b expected 0", out_valid);
    end
    // random mix, back-to-back and gaps (R1 R5 R6 R7)
    for (int i = 0; i < 60; i++) begin
      issue(2'($urandom % 4), 2'($urandom % 4), 1'($urandom), 1'($urandom),
            1'($urandom), 8'($urandom), rnd(), rnd(), rnd(), "R1");
      if (i % 5 == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R10 missing results: actual %0d pending expected 0",
               sb.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule